// File: doc/BRIEF.md
# Mixed-Length Instruction Length Stepper

This block sits in the fetch stage of a core whose instruction stream mixes 16, 32, 48 and 64-bit instructions. Each cycle it looks at a 64-bit window of instruction bytes, beginning at the current halfword-aligned fetch address. It reports how many halfwords the instruction at that address occupies and whether the instruction is legal. When the fetch side signals that the window holds that many halfwords and the consumer takes the instruction, the block moves the fetch address past it.

Length is found from a shallow look at the instruction. In the home (Standard) mode this means the six-bit major opcode plus one extra bit. In Compressed mode every instruction is one halfword. The block holds the decode state that goes with the address: the address's bit 1, the Standard/Compressed mode, and a pending one-instruction escape from Compressed mode into Standard mode.

Downstream decode tells the block when a Standard instruction switches the stream into Compressed mode, and when a compressed instruction asks for an escape. A redirect input reloads the address and both state bits together. Return and trap paths use it to restore the complete decode context.

Top module: `ilen_stepper`

## Requirements
- R1: After reset the fetch address equals the parameter RESET_ADDR, the mode is Standard (`cmp_mode_o`=0) and no escape is pending (`esc_pend_o`=0).
- R2: While the mode is Compressed and no escape is pending, `len_o` is 1 (one halfword) whatever the window holds.
- R3: When the instruction decodes as Standard, the first 32-bit word is {`win_i[15:0]`,`win_i[31:16]`} and its opcode is `win_i[15:10]`. `len_o` is given in halfwords: opcode 5 gives 1, opcode 1 gives 4, and opcode 0 gives 2 if `win_i[25]`=1 and 3 if it is 0. Every other opcode gives 2. `len_o` is never outside 1..4.
- R4: `illegal_o` is 1 in two cases: a Standard decode whose first word `win_i[31:0]` is all zeros, with `len_o`=3, or a Compressed decode whose `win_i[15:0]` is all zeros. It is 0 otherwise.
- R5: `valid_o` is 1 exactly when `win_hw_i` (the number of valid halfwords in the window) is at least `len_o`.
- R6: On a clock edge with `adv_i`=1, `valid_o`=1 and no redirect, `pc_o` increases by 2*`len_o` bytes. Otherwise, unless there is a redirect, `pc_o` holds. `pc_o[0]` is always 0.
- R7: On an advance of a Standard instruction (mode Standard, no escape pending), the mode becomes `sw_cmp_i`. Compressed mode stays until a redirect, and `sw_cmp_i` has no effect at any other time.
- R8: On an advance of a compressed instruction with `esc_i`=1, the next instruction decodes as Standard. After that instruction advances, the block is back in Compressed mode with no escape pending. `esc_i` has no effect at any other time.
- R9: A redirect loads `pc_o`=`redir_addr_i` (bit 0 cleared), the mode from `redir_cmp_i`, and the pending escape from `redir_cmp_i & redir_esc_i`. A redirect takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_i | input | 64 | Instruction window; halfword k is at bits [16k+15:16k] |
| win_hw_i | input | 3 | Number of valid halfwords in the window (0..4) |
| adv_i | input | 1 | Consumer takes the current instruction |
| sw_cmp_i | input | 1 | Current Standard instruction switches to Compressed mode |
| esc_i | input | 1 | Current compressed instruction requests one Standard instruction |
| redir_i | input | 1 | Reload the decode state |
| redir_addr_i | input | AW | Redirect target address |
| redir_cmp_i | input | 1 | Mode to load on redirect (1 = Compressed) |
| redir_esc_i | input | 1 | Pending escape to load on redirect |
| pc_o | output | AW | Current fetch address |
| cmp_mode_o | output | 1 | Home mode is Compressed |
| esc_pend_o | output | 1 | Current instruction decodes as Standard by escape |
| len_o | output | 3 | Instruction length in halfwords |
| valid_o | output | 1 | Window holds the whole instruction |
| illegal_o | output | 1 | Instruction is an illegal all-zero encoding |

## Verification
The bench targets these corner cases, and each one shows up as a specific symptom:
- Opcode 0 splits into two lengths on a single bit. A decoder that reads the wrong bit gives 48-bit lengths to the 32-bit attention form.
- An all-zero first word must decode as an illegal 48-bit instruction. A design that checks only the first halfword flags nonzero Standard words, and one that uses the wrong mode misses compressed zeros.
- The escape must last exactly one instruction. A design that clears it on a stalled cycle, or keeps it for a second instruction, misdecodes the lengths that follow.
- Mode-switch and escape inputs given without an accepted advance, and advances on a short window, must leave the address and state untouched. A redirect in the same cycle as an advance must win.

// File: rtl/ilen_pkg.sv
package ilen_pkg;
  localparam int LEN_W = 3;
  localparam logic [LEN_W-1:0] LEN_HALF = 3'd1;
  localparam logic [LEN_W-1:0] LEN_WORD = 3'd2;
  localparam logic [LEN_W-1:0] LEN_WORD_HALF = 3'd3;
  localparam logic [LEN_W-1:0] LEN_DWORD = 3'd4;
  localparam logic [5:0] OPC_ZERO = 6'd0;
  localparam logic [5:0] OPC_PREFIX = 6'd1;
  localparam logic [5:0] OPC_SHORT = 6'd5;

  typedef struct packed {
    logic cmp;
    logic pend;
  } dec_state_t;
endpackage

// File: rtl/ilen_len_decode.sv
module ilen_len_decode
  import ilen_pkg::*;
(
  input  logic [15:0]      hw0,
  input  logic [15:0]      hw1,
  input  logic             use_std,
  output logic [LEN_W-1:0] len_hw,
  output logic             illegal
);
  logic [31:0] word;
  logic [5:0]  opc;
  logic        attn_sel;

  assign word     = {hw0, hw1};
  assign opc      = word[31:26];
  assign attn_sel = word[9];

  always_comb begin
    if (!use_std) begin
      len_hw  = LEN_HALF;
      illegal = (hw0 == 16'h0000);
    end else begin
      illegal = (word == 32'h0000_0000);
      unique case (opc)
        OPC_ZERO:   len_hw = attn_sel ? LEN_WORD : LEN_WORD_HALF;
        OPC_PREFIX: len_hw = LEN_DWORD;
        OPC_SHORT:  len_hw = LEN_HALF;
        default:    len_hw = LEN_WORD;
      endcase
    end
  end
endmodule

// File: rtl/ilen_state.sv
module ilen_state
  import ilen_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_ok,
  input  logic [LEN_W-1:0] len_hw,
  input  logic             sw_cmp,
  input  logic             esc,
  input  logic             redir,
  input  logic [AW-1:0]    redir_addr,
  input  logic             redir_cmp,
  input  logic             redir_esc,
  output logic [AW-2:0]    pc_hw,
  output dec_state_t       st
);
  localparam int PAD = AW - 1 - LEN_W;

  logic [AW-2:0] step;
  assign step = {{PAD{1'b0}}, len_hw};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_hw   <= RESET_ADDR[AW-1:1];
      st.cmp  <= 1'b0;
      st.pend <= 1'b0;
    end else if (redir) begin
      pc_hw   <= redir_addr[AW-1:1];
      st.cmp  <= redir_cmp;
      st.pend <= redir_cmp & redir_esc;
    end else if (adv_ok) begin
      pc_hw <= pc_hw + step;
      if (st.pend)     st.pend <= 1'b0;
      else if (st.cmp) st.pend <= esc;
      else             st.cmp  <= sw_cmp;
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!redir && !adv_ok) |=> $stable(pc_hw)); // R6
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_ok && !redir) |=> (pc_hw == $past(pc_hw) + $past(step))); // R6
  AST_ESC_ONCE: assert property (@(posedge clk) disable iff (rst)
    (adv_ok && !redir && st.pend) |=> (!st.pend && st.cmp)); // R8
  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st.cmp && !redir) |=> st.cmp); // R7
  AST_REDIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    redir |=> (pc_hw == $past(redir_addr[AW-1:1]) && st.cmp == $past(redir_cmp))); // R9
endmodule

// File: rtl/ilen_stepper.sv
module ilen_stepper
  import ilen_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_ADDR = 32'h0000_0100,
  parameter int WIN_HW = 4,
  localparam int CW = $clog2(WIN_HW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [16*WIN_HW-1:0] win_i,
  input  logic [CW-1:0]    win_hw_i,
  input  logic             adv_i,
  input  logic             sw_cmp_i,
  input  logic             esc_i,
  input  logic             redir_i,
  input  logic [AW-1:0]    redir_addr_i,
  input  logic             redir_cmp_i,
  input  logic             redir_esc_i,
  output logic [AW-1:0]    pc_o,
  output logic             cmp_mode_o,
  output logic             esc_pend_o,
  output logic [LEN_W-1:0] len_o,
  output logic             valid_o,
  output logic             illegal_o
);
  logic [AW-2:0] pc_hw;
  dec_state_t    st;
  logic          use_std;
  logic          adv_ok;
  logic [CW-1:0] need;

  assign use_std = ~st.cmp | st.pend;

  ilen_len_decode u_dec (
    .hw0     (win_i[15:0]),
    .hw1     (win_i[31:16]),
    .use_std (use_std),
    .len_hw  (len_o),
    .illegal (illegal_o)
  );

  generate
    if (CW >= LEN_W) begin : g_wide
      assign need = CW'(len_o);
    end else begin : g_narrow
      assign need = len_o[CW-1:0];
    end
  endgenerate

  assign valid_o = (win_hw_i >= need);
  assign adv_ok  = adv_i & valid_o;

  ilen_state #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_state (
    .clk        (clk),
    .rst        (rst),
    .adv_ok     (adv_ok),
    .len_hw     (len_o),
    .sw_cmp     (sw_cmp_i),
    .esc        (esc_i),
    .redir      (redir_i),
    .redir_addr (redir_addr_i),
    .redir_cmp  (redir_cmp_i),
    .redir_esc  (redir_esc_i),
    .pc_hw      (pc_hw),
    .st         (st)
  );

  assign pc_o       = {pc_hw, 1'b0};
  assign cmp_mode_o = st.cmp;
  assign esc_pend_o = st.pend;

  AST_CMP_LEN16: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode_o && !esc_pend_o) |-> (len_o == LEN_HALF)); // R2
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (len_o >= LEN_HALF && len_o <= LEN_DWORD)); // R3
  AST_PEND_IN_CMP: assert property (@(posedge clk) disable iff (rst)
    esc_pend_o |-> cmp_mode_o); // R8
endmodule

// File: tb/ilen_stepper_bench.sv
`timescale 1ns/1ps
module ilen_stepper_bench;
  localparam int AW = 32;
  localparam logic [AW-1:0] RST_A = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst;
  logic [63:0] win;
  logic [2:0] whw;
  logic adv, swc, esc, rdr, rcmp, resc;
  logic [AW-1:0] raddr;
  logic [AW-1:0] pc;
  logic cmode, pend, vld, ill;
  logic [2:0] len;

  int errors = 0;
  int checks = 0;
  longint unsigned m_pc;
  bit m_cmp, m_pend;

  always #4 clk = ~clk;

  ilen_stepper #(.AW(AW), .RESET_ADDR(RST_A)) u_ilen_stepper (
    .clk(clk), .rst(rst), .win_i(win), .win_hw_i(whw), .adv_i(adv),
    .sw_cmp_i(swc), .esc_i(esc), .redir_i(rdr), .redir_addr_i(raddr),
    .redir_cmp_i(rcmp), .redir_esc_i(resc), .pc_o(pc), .cmp_mode_o(cmode),
    .esc_pend_o(pend), .len_o(len), .valid_o(vld), .illegal_o(ill));

  task automatic chk(string tag, longint unsigned got, longint unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_len(logic [63:0] w, bit std);
    if (!std) return 1;
    if (w[15:10] == 6'd5) return 1;
    if (w[15:10] == 6'd1) return 4;
    if (w[15:10] == 6'd0) return w[25] ? 2 : 3;
    return 2;
  endfunction

  // Drive one cycle, compare against the model, then advance the model.
  task automatic step(logic [63:0] w, int hw, bit a, bit s, bit e,
                      bit r, logic [AW-1:0] ra, bit rc, bit re);
    bit std;
    int el;
    bit ev, eil;
    @(negedge clk);
    win = w; whw = 3'(hw); adv = a; swc = s; esc = e;
    rdr = r; raddr = ra; rcmp = rc; resc = re;
    #1;
    std = !m_cmp || m_pend;
    el  = exp_len(w, std);
    ev  = (hw >= el);
    eil = std ? (w[31:0] == 32'h0) : (w[15:0] == 16'h0);
    chk("R6 pc", pc, m_pc);
    chk("R7 mode", cmode, m_cmp);
    chk("R8 pend", pend, m_pend);
    chk(std ? "R3 len" : "R2 len", len, el);
    chk("R5 valid", vld, ev);
    chk("R4 illegal", ill, eil);
    if (r) begin                                   // R9
      m_pc = ra & 32'hFFFF_FFFE; m_cmp = rc; m_pend = rc && re;
    end else if (a && ev) begin
      m_pc = (m_pc + 2 * el) & 32'hFFFF_FFFF;
      if (m_pend) m_pend = 0;
      else if (m_cmp) m_pend = e;
      else m_cmp = s;
    end
  endtask

  function automatic logic [63:0] mk(logic [5:0] opc, bit sel);
    logic [63:0] w = {$urandom, $urandom};
    w[15:10] = opc; w[25] = sel;
    return w;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; win = '0; whw = 0; adv = 0; swc = 0; esc = 0;
    rdr = 0; raddr = '0; rcmp = 0; resc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    m_pc = RST_A; m_cmp = 0; m_pend = 0;
    #1;
    chk("R1 reset pc", pc, RST_A);
    chk("R1 reset mode", cmode, 0);
    chk("R1 reset pend", pend, 0);
    // R3 standard lengths, R4 zero word, R5 short window
    step(mk(6'd5, 0), 4, 1, 0, 0, 0, 0, 0, 0);
    step(mk(6'd0, 1), 4, 1, 0, 0, 0, 0, 0, 0);
    step(mk(6'd0, 0), 4, 1, 0, 0, 0, 0, 0, 0);
    step(64'hFFFF_FFFF_0000_0000, 4, 1, 0, 0, 0, 0, 0, 0);
    step(mk(6'd1, 0), 3, 1, 0, 0, 0, 0, 0, 0);
    step(mk(6'd1, 0), 4, 1, 0, 0, 0, 0, 0, 0);
    step(mk(6'd31, 0), 4, 0, 1, 0, 0, 0, 0, 0);
    // R7 switch to compressed, R2, R8 escape lasting one instruction
    step(mk(6'd31, 0), 4, 1, 1, 0, 0, 0, 0, 0);
    step(mk(6'd1, 0), 4, 1, 0, 1, 0, 0, 0, 0);
    step(mk(6'd1, 0), 0, 1, 0, 0, 0, 0, 0, 0);
    step(mk(6'd1, 0), 4, 1, 0, 0, 0, 0, 0, 0);
    step(64'h0, 4, 1, 0, 0, 0, 0, 0, 0);
    // R9 redirect beats advance, plain redirect back to standard
    step(mk(6'd1, 0), 4, 1, 0, 0, 1, 32'h2002, 1, 1);
    step(mk(6'd1, 0), 4, 1, 0, 0, 1, 32'h0400, 0, 1);
    step(mk(6'd0, 1), 4, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] w = {$urandom, $urandom};
      int k = $urandom % 8;
      if (k == 0) w[15:10] = 0;
      if (k == 1) w[15:10] = 1;
      if (k == 2) w[15:10] = 5;
      if (k == 3) w[31:0] = 0;
      if (k == 4) w[15:0] = 0;
      step(w, ($urandom % 4 == 0) ? $urandom % 5 : 4, ($urandom % 4) != 0,
           ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 20) == 0,
           $urandom, $urandom % 2, $urandom % 2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule